// File: doc/BRIEF.md
# Register Rename Manager with Branch Recovery

This block manages register renaming for an out-of-order core. It maps a small set of architectural registers onto a larger pool of physical registers. It tracks which physical registers are unused and which already hold a result. It keeps a circular window of in-flight instruction records. The records carry bookkeeping only and no data values. Each record remembers the physical register its destination replaced. At retirement, that older register goes back to the pool.

Each branch that is renamed takes a snapshot slot, and the whole mapping table is copied into that slot. When a branch resolves as mispredicted, one recovery cycle does three things:
- it discards every record younger than the branch;
- it returns their newly taken physical registers to the pool;
- it copies the snapshot back into the mapping table.

Allocation picks up again on the following cycle, at the slot right after the branch.

The front end offers one instruction per cycle on the allocate port. Functional units report completion by record index. The branch unit reports resolution by snapshot tag. The retirement side watches the commit outputs, which present at most one record per cycle.

Top module: `rename_rob`

## Requirements
- R1: After reset, architectural register k maps to physical register k. Physical registers 8 to 15 are free. All physical registers are present. The window is empty, so `commitValid` is 0 and the first allocation gets index 0.
- R2: A destination receives the lowest-numbered free physical register. A source reports the current mapping, including the renames of earlier allocations.
- R3: `allocRdy1` and `allocRdy2` give the present bit of the mapped source register. A register taken as a destination stays not present until its record completes execution.
- R4: There is no bypass. A completion in cycle t is not visible as ready to an allocation in cycle t, and it cannot retire in cycle t. Both become possible in cycle t+1.
- R5: Commit is strictly in order. The oldest record retires only once it has executed, and younger executed records wait behind it.
- R6: Commit reports the architectural destination (`commitArch`), the new physical register (`commitPdst`) and the replaced physical register (`commitPrev`). The replaced register returns to the free pool, so a later allocation can receive it.
- R7: `allocReady` is 0 while the window holds 8 records, and while a destination is requested and no physical register is free.
- R8: A branch takes the lowest free snapshot tag out of 4. While all tags are held, a branch cannot allocate but a non-branch can. A correct resolution frees the tag for the next cycle.
- R9: A branch record does not retire while its tag is unresolved, even if it has executed.
- R10: In a mispredict cycle `allocReady` is 0. On the next cycle:
  - `allocIdx` equals the branch index plus 1;
  - the mapping equals the snapshot taken at the branch;
  - the discarded destinations are free again;
  - the tags of younger branches are free again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Instruction offered for rename |
| allocReady | output | 1 | Rename accepted this cycle when valid |
| allocOp | input | 4 | Opcode stored in the record |
| allocSrc1 | input | 3 | Architectural source 1 |
| allocSrc2 | input | 3 | Architectural source 2 |
| allocDst | input | 3 | Architectural destination |
| allocWrDst | input | 1 | Instruction writes a destination |
| allocIsBranch | input | 1 | Instruction is a branch (takes a snapshot) |
| allocIdx | output | 3 | Record index the instruction receives |
| allocTag | output | 2 | Snapshot tag a branch receives |
| allocPdst | output | 4 | Physical destination picked |
| allocPsrc1 | output | 4 | Physical tag of source 1 |
| allocPsrc2 | output | 4 | Physical tag of source 2 |
| allocRdy1 | output | 1 | Source 1 value present |
| allocRdy2 | output | 1 | Source 2 value present |
| execValid | input | 1 | A record finished execution |
| execIdx | input | 3 | Index of that record |
| resolveValid | input | 1 | A branch resolved |
| resolveMispredict | input | 1 | Resolution was a mispredict |
| resolveTag | input | 2 | Snapshot tag of the resolved branch |
| commitValid | output | 1 | Oldest record retires this cycle |
| commitIdx | output | 3 | Index of the retiring record |
| commitOp | output | 4 | Opcode of the retiring record |
| commitArch | output | 3 | Architectural destination retiring |
| commitWrDst | output | 1 | Retiring record had a destination |
| commitPdst | output | 4 | Physical register that becomes architectural |
| commitPrev | output | 4 | Replaced physical register, freed now |

## Verification
The hardest state to reach is a mispredict that has to undo several things together:
- renames of one architectural register across the branch boundary;
- a younger branch that holds its own snapshot tag;
- destinations taken after the branch.

The stimulus reaches it by renaming r1 on both sides of a first branch, placing a second branch and another rename behind it, and then mispredicting the first branch. On the next cycle, the source tags show whether the mapping was restored, the picked destination shows whether the flushed register returned to the pool, and the tags given to two fresh branches show whether the younger tag was released. Full-window and all-tags-held states are reached by filling the window without retiring, and wrap-around of the index by retiring from the head first.

// File: rtl/rename_pkg.sv
`timescale 1ns/1ps
package rename_pkg;
  localparam int ARCH_REGS  = 8;
  localparam int PHYS_REGS  = 16;
  localparam int ROB_SLOTS  = 8;
  localparam int SNAP_SLOTS = 4;
  localparam int OP_BITS    = 4;
  localparam int AW = $clog2(ARCH_REGS);
  localparam int PW = $clog2(PHYS_REGS);
  localparam int RW = $clog2(ROB_SLOTS);
  localparam int SW = $clog2(SNAP_SLOTS);

  // strobes from control to datapath
  typedef struct packed {
    logic                 doAlloc;
    logic                 doCommit;
    logic                 doRecover;
    logic [RW-1:0]        allocIdx;
    logic [RW-1:0]        headIdx;
    logic [SW-1:0]        snapTag;
    logic [SW-1:0]        resolveTag;
    logic [ROB_SLOTS-1:0] flushMask;
  } strobe_t;
endpackage

// File: rtl/rename_ctrl.sv
`timescale 1ns/1ps
module rename_ctrl
  import rename_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          allocValid,
  input  logic          allocWrDst,
  input  logic          allocIsBranch,
  input  logic          freeEmpty,
  input  logic          headExec,
  input  logic          headIsBranch,
  input  logic [SW-1:0] headBrTag,
  input  logic          resolveValid,
  input  logic          resolveMispredict,
  input  logic [SW-1:0] resolveTag,
  output logic          allocReady,
  output strobe_t       strobe
);
  logic [RW-1:0]         head, tail;
  logic [RW:0]           count;
  logic [SNAP_SLOTS-1:0] snapValid, killSnap, setSnap, relSnap;
  logic [RW-1:0]         snapBrIdx [SNAP_SLOTS];
  logic [SW-1:0]         pickTag;
  logic                  anyFree, full, doAlloc, doCommit, doRelease, doRecover;
  logic [RW-1:0]         brIdx, brAge;
  logic [ROB_SLOTS-1:0]  flushVec;

  always_comb begin
    anyFree = 1'b0;
    pickTag = '0;
    for (int s = SNAP_SLOTS-1; s >= 0; s--)
      if (!snapValid[s]) begin
        anyFree = 1'b1;
        pickTag = SW'(s);
      end
  end

  assign full       = (count == (RW+1)'(ROB_SLOTS));
  assign allocReady = !full && !(allocWrDst && freeEmpty) &&
                      !(allocIsBranch && !anyFree) &&
                      !(resolveValid && resolveMispredict);
  assign doAlloc    = allocValid && allocReady;
  assign doCommit   = (count != '0) && headExec && !(headIsBranch && snapValid[headBrTag]);
  assign doRelease  = resolveValid && snapValid[resolveTag];
  assign doRecover  = doRelease && resolveMispredict;
  assign brIdx      = snapBrIdx[resolveTag];
  assign brAge      = brIdx - head;

  genvar g;
  for (g = 0; g < ROB_SLOTS; g++) begin : gFlush
    logic [RW-1:0] entAge;
    assign entAge      = RW'(g) - head;
    assign flushVec[g] = doRecover && ({1'b0, entAge} < count) && (entAge > brAge);
  end

  always_comb begin
    killSnap = '0;
    relSnap  = '0;
    setSnap  = '0;
    for (int s = 0; s < SNAP_SLOTS; s++)
      killSnap[s] = doRecover && snapValid[s] && ((snapBrIdx[s] - head) > brAge);
    if (doRelease) relSnap[resolveTag] = 1'b1;
    if (doAlloc && allocIsBranch) setSnap[pickTag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      snapValid <= '0;
      for (int s = 0; s < SNAP_SLOTS; s++) snapBrIdx[s] <= '0;
    end else begin
      head <= head + RW'(doCommit);
      if (doRecover) begin
        tail  <= brIdx + RW'(1);
        count <= {1'b0, brAge} + (RW+1)'(1) - (RW+1)'(doCommit);
      end else begin
        tail  <= tail + RW'(doAlloc);
        count <= count + (RW+1)'(doAlloc) - (RW+1)'(doCommit);
      end
      snapValid <= (snapValid & ~killSnap & ~relSnap) | setSnap;
      if (doAlloc && allocIsBranch) snapBrIdx[pickTag] <= tail;
    end
  end

  always_comb begin
    strobe.doAlloc    = doAlloc;
    strobe.doCommit   = doCommit;
    strobe.doRecover  = doRecover;
    strobe.allocIdx   = tail;
    strobe.headIdx    = head;
    strobe.snapTag    = pickTag;
    strobe.resolveTag = resolveTag;
    strobe.flushMask  = flushVec;
  end
endmodule

// File: rtl/rename_dpath.sv
`timescale 1ns/1ps
module rename_dpath
  import rename_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [OP_BITS-1:0] allocOp,
  input  logic [AW-1:0]      allocSrc1,
  input  logic [AW-1:0]      allocSrc2,
  input  logic [AW-1:0]      allocDst,
  input  logic               allocWrDst,
  input  logic               allocIsBranch,
  input  logic               execValid,
  input  logic [RW-1:0]      execIdx,
  output logic               freeEmpty,
  output logic               headExec,
  output logic               headIsBranch,
  output logic [SW-1:0]      headBrTag,
  output logic [PW-1:0]      allocPdst,
  output logic [PW-1:0]      allocPsrc1,
  output logic [PW-1:0]      allocPsrc2,
  output logic               allocRdy1,
  output logic               allocRdy2,
  output logic [OP_BITS-1:0] commitOp,
  output logic [AW-1:0]      commitArch,
  output logic               commitWrDst,
  output logic [PW-1:0]      commitPdst,
  output logic [PW-1:0]      commitPrev
);
  logic [ROB_SLOTS-1:0]  robUse, robExec, robWr, robBr, useNext;
  logic [OP_BITS-1:0]    robOp   [ROB_SLOTS];
  logic [AW-1:0]         robArch [ROB_SLOTS];
  logic [PW-1:0]         robNew  [ROB_SLOTS];
  logic [PW-1:0]         robPrev [ROB_SLOTS];
  logic [SW-1:0]         robTag  [ROB_SLOTS];
  logic [PW-1:0]         mapTbl  [ARCH_REGS];
  logic [PW-1:0]         mapAfter[ARCH_REGS];
  logic [PW-1:0]         snapTbl [SNAP_SLOTS][ARCH_REGS];
  logic [PHYS_REGS-1:0]  freeMask, freeNext, present, presentNext;
  logic [PW-1:0]         pick;
  logic [RW-1:0]         h, a;

  assign h = strobe.headIdx;
  assign a = strobe.allocIdx;

  always_comb begin
    pick = '0;
    for (int p = PHYS_REGS-1; p >= 0; p--)
      if (freeMask[p]) pick = PW'(p);
  end

  assign freeEmpty    = (freeMask == '0);
  assign allocPdst    = pick;
  assign allocPsrc1   = mapTbl[allocSrc1];
  assign allocPsrc2   = mapTbl[allocSrc2];
  assign allocRdy1    = present[allocPsrc1];
  assign allocRdy2    = present[allocPsrc2];
  assign headExec     = robUse[h] && robExec[h];
  assign headIsBranch = robBr[h];
  assign headBrTag    = robTag[h];
  assign commitOp     = robOp[h];
  assign commitArch   = robArch[h];
  assign commitWrDst  = robWr[h];
  assign commitPdst   = robNew[h];
  assign commitPrev   = robPrev[h];

  always_comb begin
    mapAfter = mapTbl;
    if (allocWrDst) mapAfter[allocDst] = pick;
  end

  always_comb begin
    freeNext    = freeMask;
    presentNext = present;
    useNext     = robUse & ~strobe.flushMask;
    if (execValid && robUse[execIdx] && robWr[execIdx]) presentNext[robNew[execIdx]] = 1'b1;
    if (strobe.doCommit) begin
      useNext[h] = 1'b0;
      if (robWr[h]) freeNext[robPrev[h]] = 1'b1;
    end
    for (int i = 0; i < ROB_SLOTS; i++)
      if (strobe.flushMask[i] && robWr[i]) freeNext[robNew[i]] = 1'b1;
    if (strobe.doAlloc) begin
      useNext[a] = 1'b1;
      if (allocWrDst) begin
        freeNext[pick]    = 1'b0;
        presentNext[pick] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      robUse   <= '0;
      robExec  <= '0;
      robWr    <= '0;
      robBr    <= '0;
      present  <= '1;
      for (int p = 0; p < PHYS_REGS; p++) freeMask[p] <= (p >= ARCH_REGS);
      for (int r = 0; r < ARCH_REGS; r++) mapTbl[r] <= PW'(r);
      for (int i = 0; i < ROB_SLOTS; i++) begin
        robOp[i] <= '0; robArch[i] <= '0; robNew[i] <= '0;
        robPrev[i] <= '0; robTag[i] <= '0;
      end
      for (int s = 0; s < SNAP_SLOTS; s++)
        for (int r = 0; r < ARCH_REGS; r++) snapTbl[s][r] <= PW'(r);
    end else begin
      robUse   <= useNext;
      freeMask <= freeNext;
      present  <= presentNext;
      if (execValid && robUse[execIdx]) robExec[execIdx] <= 1'b1;
      if (strobe.doAlloc) begin
        robExec[a] <= 1'b0;
        robWr[a]   <= allocWrDst;
        robBr[a]   <= allocIsBranch;
        robOp[a]   <= allocOp;
        robArch[a] <= allocDst;
        robNew[a]  <= pick;
        robPrev[a] <= mapTbl[allocDst];
        robTag[a]  <= strobe.snapTag;
        if (allocIsBranch) snapTbl[strobe.snapTag] <= mapAfter;
      end
      if (strobe.doRecover) mapTbl <= snapTbl[strobe.resolveTag];
      else if (strobe.doAlloc) mapTbl <= mapAfter;
    end
  end
endmodule

// File: rtl/rename_rob.sv
`timescale 1ns/1ps
module rename_rob
  import rename_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         allocValid,
  output logic         allocReady,
  input  logic [3:0]   allocOp,
  input  logic [2:0]   allocSrc1,
  input  logic [2:0]   allocSrc2,
  input  logic [2:0]   allocDst,
  input  logic         allocWrDst,
  input  logic         allocIsBranch,
  output logic [2:0]   allocIdx,
  output logic [1:0]   allocTag,
  output logic [3:0]   allocPdst,
  output logic [3:0]   allocPsrc1,
  output logic [3:0]   allocPsrc2,
  output logic         allocRdy1,
  output logic         allocRdy2,
  input  logic         execValid,
  input  logic [2:0]   execIdx,
  input  logic         resolveValid,
  input  logic         resolveMispredict,
  input  logic [1:0]   resolveTag,
  output logic         commitValid,
  output logic [2:0]   commitIdx,
  output logic [3:0]   commitOp,
  output logic [2:0]   commitArch,
  output logic         commitWrDst,
  output logic [3:0]   commitPdst,
  output logic [3:0]   commitPrev
);
  strobe_t       strobe;
  logic          freeEmpty, headExec, headIsBranch;
  logic [SW-1:0] headBrTag;

  rename_ctrl uCtrl (
    .clk, .rstN, .allocValid, .allocWrDst, .allocIsBranch, .freeEmpty,
    .headExec, .headIsBranch, .headBrTag, .resolveValid, .resolveMispredict,
    .resolveTag, .allocReady, .strobe
  );

  rename_dpath uDpath (
    .clk, .rstN, .strobe, .allocOp, .allocSrc1, .allocSrc2, .allocDst,
    .allocWrDst, .allocIsBranch, .execValid, .execIdx, .freeEmpty, .headExec,
    .headIsBranch, .headBrTag, .allocPdst, .allocPsrc1, .allocPsrc2,
    .allocRdy1, .allocRdy2, .commitOp, .commitArch, .commitWrDst,
    .commitPdst, .commitPrev
  );

  assign allocIdx    = strobe.allocIdx;
  assign allocTag    = strobe.snapTag;
  assign commitValid = strobe.doCommit;
  assign commitIdx   = strobe.headIdx;
endmodule

// File: rtl/rename_rob_chk.sv
`timescale 1ns/1ps
module rename_rob_chk
  import rename_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         allocValid,
  input logic         allocReady,
  input logic         allocIsBranch,
  input logic [2:0]   allocIdx,
  input logic [1:0]   allocTag,
  input logic         execValid,
  input logic [2:0]   execIdx,
  input logic         resolveValid,
  input logic         resolveMispredict,
  input logic [1:0]   resolveTag,
  input logic         commitValid,
  input logic [2:0]   commitIdx
);
  logic                  accept, recov;
  logic [RW-1:0]         headSh, expTail;
  logic [RW:0]           occ;
  logic                  expChk;
  logic [ROB_SLOTS-1:0]  doneMask, isBrSh;
  logic [SNAP_SLOTS-1:0] openTag;
  logic [RW-1:0]         brIdxSh [SNAP_SLOTS];
  logic [SW-1:0]         tagSh   [ROB_SLOTS];

  assign accept = allocValid && allocReady;
  assign recov  = resolveValid && resolveMispredict && openTag[resolveTag];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headSh   <= '0;
      occ      <= '0;
      expChk   <= 1'b0;
      expTail  <= '0;
      doneMask <= '0;
      isBrSh   <= '0;
      openTag  <= '0;
      for (int s = 0; s < SNAP_SLOTS; s++) brIdxSh[s] <= '0;
      for (int i = 0; i < ROB_SLOTS; i++) tagSh[i] <= '0;
    end else begin
      headSh  <= headSh + RW'(commitValid);
      expChk  <= recov;
      expTail <= brIdxSh[resolveTag] + RW'(1);
      if (recov)
        occ <= {1'b0, brIdxSh[resolveTag] - headSh} + (RW+1)'(1) - (RW+1)'(commitValid);
      else
        occ <= occ + (RW+1)'(accept) - (RW+1)'(commitValid);
      if (execValid) doneMask[execIdx] <= 1'b1;
      if (accept) begin
        doneMask[allocIdx] <= 1'b0;
        isBrSh[allocIdx]   <= allocIsBranch;
        tagSh[allocIdx]    <= allocTag;
      end
      if (resolveValid) openTag[resolveTag] <= 1'b0;
      if (accept && allocIsBranch) begin
        openTag[allocTag] <= 1'b1;
        brIdxSh[allocTag] <= allocIdx;
      end
    end
  end

  // R5
  commit_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> commitIdx == headSh);

  // R4
  exec_before_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> doneMask[commitIdx]);

  // R9
  branch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && isBrSh[commitIdx]) |-> !openTag[tagSh[commitIdx]]);

  // R10
  rollback_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    expChk |-> allocIdx == expTail);

  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == (RW+1)'(ROB_SLOTS)) |-> !allocReady);
endmodule

bind rename_rob rename_rob_chk chk (.*);

// File: tb/rename_rob_test.sv
`timescale 1ns/1ps
module rename_rob_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid, allocWrDst, allocIsBranch, allocReady;
  logic [3:0] allocOp;
  logic [2:0] allocSrc1, allocSrc2, allocDst, allocIdx;
  logic [1:0] allocTag;
  logic [3:0] allocPdst, allocPsrc1, allocPsrc2;
  logic allocRdy1, allocRdy2;
  logic execValid;
  logic [2:0] execIdx;
  logic resolveValid, resolveMispredict;
  logic [1:0] resolveTag;
  logic commitValid, commitWrDst;
  logic [2:0] commitIdx, commitArch;
  logic [3:0] commitOp, commitPdst, commitPrev;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rename_rob uut (.*);

  typedef struct packed {
    logic       wr;
    logic [2:0] dst;
    logic [2:0] src1;
    logic [2:0] idx;
    logic [3:0] pdst;
    logic [3:0] psrc1;
    logic       rdy1;
  } vec_t;

  // R2 R3: rename chain from reset
  localparam vec_t VECS [5] = '{
    '{1'b1, 3'd1, 3'd1, 3'd0, 4'd8,  4'd1,  1'b1},
    '{1'b1, 3'd2, 3'd1, 3'd1, 4'd9,  4'd8,  1'b0},
    '{1'b1, 3'd1, 3'd2, 3'd2, 4'd10, 4'd9,  1'b0},
    '{1'b1, 3'd3, 3'd1, 3'd3, 4'd11, 4'd10, 1'b0},
    '{1'b0, 3'd0, 3'd3, 3'd4, 4'd12, 4'd11, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    allocValid = 0; allocWrDst = 0; allocIsBranch = 0; allocOp = 0;
    allocSrc1 = 0; allocSrc2 = 0; allocDst = 0;
    execValid = 0; execIdx = 0;
    resolveValid = 0; resolveMispredict = 0; resolveTag = 0;
  endtask

  task automatic alloc(input logic br, input logic wr, input logic [2:0] d,
                       input logic [2:0] s1, input logic [2:0] s2);
    allocValid = 1; allocIsBranch = br; allocWrDst = wr;
    allocDst = d; allocSrc1 = s1; allocSrc2 = s2; allocOp = {1'b0, d};
  endtask

  task automatic nextCycle();
    @(negedge clk);
    idle();
  endtask

  task automatic doReset();
    @(negedge clk);
    idle();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    idle();
    doReset();

    // R1 reset state
    nextCycle(); #1;
    chk("R1 commitValid", commitValid, 0);
    chk("R1 allocIdx", allocIdx, 0);
    chk("R1 allocReady", allocReady, 1);
    allocSrc1 = 3'd5; allocSrc2 = 3'd7; #1;
    chk("R1 identity src1", allocPsrc1, 5);
    chk("R1 identity src2", allocPsrc2, 7);
    chk("R1 present", allocRdy2, 1);

    // R2 R3 table walk
    for (int v = 0; v < 5; v++) begin
      nextCycle();
      alloc(1'b0, VECS[v].wr, VECS[v].dst, VECS[v].src1, 3'd0);
      #1;
      chk("R2 idx", allocIdx, VECS[v].idx);
      chk("R2 pdst", allocPdst, VECS[v].pdst);
      chk("R2 psrc1", allocPsrc1, VECS[v].psrc1);
      chk("R3 rdy1", allocRdy1, VECS[v].rdy1);
    end

    // R4 completion of idx2 (p10) not visible in same cycle
    nextCycle();
    alloc(1'b0, 1'b1, 3'd4, 3'd1, 3'd0);
    execValid = 1; execIdx = 3'd2; #1;
    chk("R4 same-cycle rdy", allocRdy1, 0);
    chk("R2 pdst idx5", allocPdst, 12);
    nextCycle();
    alloc(1'b0, 1'b0, 3'd0, 3'd1, 3'd0);
    execValid = 1; execIdx = 3'd0; #1;
    chk("R4 next-cycle rdy", allocRdy1, 1);
    chk("R4 no same-cycle commit", commitValid, 0);
    nextCycle(); #1;
    chk("R5 commitValid", commitValid, 1);
    chk("R5 commitIdx", commitIdx, 0);
    chk("R6 commitArch", commitArch, 1);
    chk("R6 commitPdst", commitPdst, 8);
    chk("R6 commitPrev", commitPrev, 1);
    nextCycle(); #1;
    chk("R5 head not executed", commitValid, 0);
    nextCycle();
    alloc(1'b0, 1'b1, 3'd5, 3'd0, 3'd0); #1;
    chk("R6 freed reg reused", allocPdst, 1);
    chk("R6 idx7", allocIdx, 7);
    nextCycle();
    alloc(1'b0, 1'b0, 3'd0, 3'd0, 3'd0); #1;
    chk("R7 wrap idx", allocIdx, 0);
    chk("R7 ready at 7", allocReady, 1);
    nextCycle();
    alloc(1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
    execValid = 1; execIdx = 3'd1; #1;
    chk("R7 full stall", allocReady, 0);
    nextCycle(); #1;
    chk("R5 commit idx1", commitIdx, 1);
    chk("R6 prev idx1", commitPrev, 2);
    chk("R5 commit valid idx1", commitValid, 1);
    nextCycle(); #1;
    chk("R5 commit idx2", commitIdx, 2);
    chk("R6 prev idx2", commitPrev, 8);
    nextCycle(); #1;
    chk("R5 idx3 waits", commitValid, 0);

    // R10 mispredict recovery
    doReset();
    nextCycle(); alloc(1'b0, 1'b1, 3'd1, 3'd1, 3'd0); #1;
    chk("R10 setup pdst", allocPdst, 8);
    nextCycle(); alloc(1'b1, 1'b0, 3'd0, 3'd1, 3'd0); #1;
    chk("R8 first tag", allocTag, 0);
    nextCycle(); alloc(1'b0, 1'b1, 3'd1, 3'd1, 3'd0); #1;
    chk("R2 psrc after rename", allocPsrc1, 8);
    chk("R2 pdst 9", allocPdst, 9);
    nextCycle(); alloc(1'b1, 1'b0, 3'd0, 3'd0, 3'd0); #1;
    chk("R8 second tag", allocTag, 1);
    nextCycle(); alloc(1'b0, 1'b1, 3'd2, 3'd0, 3'd0); #1;
    chk("R2 pdst 10", allocPdst, 10);
    nextCycle();
    alloc(1'b0, 1'b1, 3'd3, 3'd1, 3'd2);
    resolveValid = 1; resolveMispredict = 1; resolveTag = 2'd0; #1;
    chk("R10 stall in recovery", allocReady, 0);
    nextCycle(); alloc(1'b0, 1'b1, 3'd3, 3'd1, 3'd2); #1;
    chk("R10 tail rollback", allocIdx, 2);
    chk("R10 map restored r1", allocPsrc1, 8);
    chk("R10 map restored r2", allocPsrc2, 2);
    chk("R10 flushed reg free", allocPdst, 9);
    nextCycle(); alloc(1'b1, 1'b0, 3'd0, 3'd0, 3'd0); #1;
    chk("R10 tag0 released", allocTag, 0);
    chk("R10 idx3", allocIdx, 3);
    nextCycle(); alloc(1'b1, 1'b0, 3'd0, 3'd0, 3'd0); #1;
    chk("R10 younger tag released", allocTag, 1);

    // R9 branch held until resolved
    doReset();
    nextCycle(); alloc(1'b1, 1'b0, 3'd0, 3'd0, 3'd0); #1;
    chk("R9 branch tag", allocTag, 0);
    nextCycle(); execValid = 1; execIdx = 3'd0; #1;
    nextCycle(); #1;
    chk("R9 executed but unresolved", commitValid, 0);
    nextCycle(); resolveValid = 1; resolveTag = 2'd0; #1;
    chk("R9 resolve cycle", commitValid, 0);
    nextCycle(); #1;
    chk("R9 commit after resolve", commitValid, 1);
    chk("R9 commit no dst", commitWrDst, 0);

    // R8 snapshot exhaustion
    doReset();
    for (int t = 0; t < 4; t++) begin
      nextCycle(); alloc(1'b1, 1'b0, 3'd0, 3'd0, 3'd0); #1;
      chk("R8 tag order", allocTag, t);
    end
    nextCycle(); allocIsBranch = 1; #1;
    chk("R8 branch stalls", allocReady, 0);
    allocIsBranch = 0; allocWrDst = 1; #1;
    chk("R8 non-branch allowed", allocReady, 1);
    nextCycle(); resolveValid = 1; resolveTag = 2'd2; #1;
    nextCycle(); allocIsBranch = 1; #1;
    chk("R8 released tag ready", allocReady, 1);
    chk("R8 released tag value", allocTag, 2);

    nextCycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule